// File: doc/BRIEF.md
# GF(2^81) Binary-Euclid Field Inverter

This block returns the multiplicative inverse of one element of the binary field GF(2^81). Elements use a polynomial basis reduced by x^81 + x^4 + 1, and bit i of every bus holds the coefficient of x^i. The inverse comes from a shift-and-XOR greatest-common-divisor iteration that runs on the operand and the field polynomial together. Each iteration takes one clock cycle, so both run time and hardware grow linearly with the field degree.

A controller pulses `start_i` with the operand on `operand_i`. The block then runs exactly 2·m iterations, which is 162 for m = 81, whatever the operand value. After that it raises `done_o` for one cycle. The result and the zero flag stay on the outputs until the next operation completes. A zero operand has no inverse. It still takes the full 162 cycles, then returns zero with `zero_err_o` set, so a fixed schedule around the inverter never has to branch.

Top module: `gf_inverter`

## Requirements
- R1: After reset, `done_o`, `zero_err_o` and every bit of `result_o` are 0.
- R2: A rising edge where `start_i` is 1 and no operation is running captures `operand_i` and begins an operation.
- R3: `done_o` is 1 for exactly one cycle, starting 2·m = 162 rising edges after the capturing edge.
- R4: For a nonzero operand a, `result_o` at completion equals a^-1 mod x^81 + x^4 + 1, so that a·result_o = 1 in the field.
- R5: A zero operand completes at the same time as any other, with `result_o` = 0 and `zero_err_o` = 1.
- R6: `start_i` and `operand_i` are ignored while an operation is running: neither the completion time nor the result of the running operation changes.
- R7: `result_o` and `zero_err_o` change only at the edge that raises `done_o`, and otherwise hold their values.
- R8: A nonzero operand completes with `zero_err_o` = 0, clearing a flag left set by an earlier zero operand.
- R9: Corner values: the inverse of 1 is 1, and the inverse of x (bit 1 only) is x^80 + x^3 (bits 80 and 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only while idle |
| operand_i | input | 81 | Element to invert, polynomial basis |
| result_o | output | 81 | Inverse of the last completed operand |
| done_o | output | 1 | One-cycle completion pulse |
| zero_err_o | output | 1 | Set when the last completed operand was zero |

## Verification
Results are due 162 rising edges after the edge that captures the start request. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the one where it drives the request, so the first `done_o` must show up on the 163rd. The bench reads the result and the flag there and checks that the pulse is gone one falling edge later. Each result is checked by multiplying it with the operand in a reference shift-and-add multiplier and comparing the product with 1. A second request raised mid-run must leave both the completion edge and the product unchanged.

// File: rtl/gf_inv_pkg.sv
package gf_inv_pkg;

    // Field degree and the low-order terms of the reduction polynomial
    // x^81 + x^4 + 1 (bits 4 and 0).
    localparam int unsigned FIELD_M    = 81;
    localparam logic [FIELD_M-1:0] FIELD_TAPS = 81'h11;

endpackage

// File: rtl/gf_xscale.sv
// Multiply and divide a field element by x, modulo x^M + TAPS.
module gf_xscale #(
    parameter int unsigned M          = 81,
    parameter logic [M-1:0] TAPS      = 81'h11
) (
    input  logic [M-1:0] a_i,
    output logic [M-1:0] up_o,
    output logic [M-1:0] down_o
);

    localparam logic [M-1:0] TOP_BIT = {1'b1, {(M-1){1'b0}}};

    always_comb begin
        up_o = {a_i[M-2:0], 1'b0};
        if (a_i[M-1]) begin
            up_o = up_o ^ TAPS;
        end
    end

    // With the constant term of the polynomial equal to 1, an odd element
    // becomes even after adding the polynomial, and then divides exactly by x.
    always_comb begin
        if (a_i[0]) begin
            down_o = ((a_i ^ TAPS) >> 1) | TOP_BIT;
        end else begin
            down_o = a_i >> 1;
        end
    end

endmodule

// File: rtl/gf_euclid_step.sv
// One iteration of the fixed-length binary gcd inversion.
// r and s are (M+1)-bit, top-aligned at bit M; u and v are the cofactors.
module gf_euclid_step #(
    parameter int unsigned M          = 81,
    parameter logic [M-1:0] TAPS      = 81'h11,
    parameter int unsigned DW         = 8
) (
    input  logic [M:0]    r_i,
    input  logic [M:0]    s_i,
    input  logic [M-1:0]  u_i,
    input  logic [M-1:0]  v_i,
    input  logic [DW-1:0] delta_i,
    output logic [M:0]    r_o,
    output logic [M:0]    s_o,
    output logic [M-1:0]  u_o,
    output logic [M-1:0]  v_o,
    output logic [DW-1:0] delta_o
);

    logic [M:0]   s_red;
    logic [M:0]   s_shift;
    logic [M-1:0] v_red;
    logic [M-1:0] u_up;
    logic [M-1:0] u_down;
    logic [M-1:0] vred_up;
    logic [M-1:0] vred_down;

    gf_xscale #(.M(M), .TAPS(TAPS)) i_scale_u (
        .a_i    (u_i),
        .up_o   (u_up),
        .down_o (u_down)
    );

    gf_xscale #(.M(M), .TAPS(TAPS)) i_scale_v (
        .a_i    (v_red),
        .up_o   (vred_up),
        .down_o (vred_down)
    );

    always_comb begin
        s_red   = s_i[M] ? (s_i ^ r_i) : s_i;
        v_red   = s_i[M] ? (v_i ^ u_i) : v_i;
        s_shift = {s_red[M-1:0], 1'b0};
    end

    always_comb begin
        r_o     = r_i;
        s_o     = s_i;
        u_o     = u_i;
        v_o     = v_i;
        delta_o = delta_i;
        if (!r_i[M]) begin
            // leading term of r not yet aligned: shift r up
            r_o     = {r_i[M-1:0], 1'b0};
            u_o     = u_up;
            delta_o = delta_i + 1'b1;
        end else if (delta_i == '0) begin
            // reduce s by r, then exchange roles
            r_o     = s_shift;
            s_o     = r_i;
            u_o     = vred_up;
            v_o     = u_i;
            delta_o = {{(DW-1){1'b0}}, 1'b1};
        end else begin
            s_o     = s_shift;
            v_o     = v_red;
            u_o     = u_down;
            delta_o = delta_i - 1'b1;
        end
    end

    // the unused divided copy of the reduced v is intentionally dropped
    logic unused_vdown;
    assign unused_vdown = ^vred_down;

endmodule

// File: rtl/gf_inv_ctrl.sv
// Iteration counter: accepts a start while idle, runs ITERS cycles,
// pulses done on the last one.
module gf_inv_ctrl #(
    parameter int unsigned ITERS = 162,
    localparam int unsigned CW   = $clog2(ITERS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic accept_o,
    output logic iter_o,
    output logic last_o,
    output logic done_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          busy;
        logic          done;
    } ctrl_t;

    ctrl_t st_d, st_q;

    localparam logic [CW-1:0] ITERS_C = CW'(ITERS);
    localparam logic [CW-1:0] ONE_C   = CW'(1);

    always_comb begin
        accept_o = start_i && !st_q.busy;
        iter_o   = st_q.busy;
        last_o   = st_q.busy && (st_q.cnt == ONE_C);
        st_d     = st_q;
        st_d.done = last_o;
        if (accept_o) begin
            st_d.busy = 1'b1;
            st_d.cnt  = ITERS_C;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (last_o) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R3
    cnt_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt != '0 && st_q.cnt <= ITERS_C));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !st_q.busy) |=> (st_q.busy && st_q.cnt == ITERS_C));

endmodule

// File: rtl/gf_inverter.sv
module gf_inverter
    import gf_inv_pkg::*;
#(
    parameter int unsigned M        = FIELD_M,
    parameter logic [M-1:0] TAPS    = FIELD_TAPS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [M-1:0] operand_i,
    output logic [M-1:0] result_o,
    output logic         done_o,
    output logic         zero_err_o
);

    localparam int unsigned ITERS = 2 * M;
    localparam int unsigned DW    = $clog2(ITERS + 2);

    typedef struct packed {
        logic [M:0]    r;
        logic [M:0]    s;
        logic [M-1:0]  u;
        logic [M-1:0]  v;
        logic [DW-1:0] delta;
        logic          zero;
        logic [M-1:0]  result;
        logic          err;
    } dp_t;

    dp_t dp_d, dp_q;

    logic          accept;
    logic          iter;
    logic          last;
    logic          done_q;
    logic [M:0]    r_nx;
    logic [M:0]    s_nx;
    logic [M-1:0]  u_nx;
    logic [M-1:0]  v_nx;
    logic [DW-1:0] delta_nx;

    gf_inv_ctrl #(.ITERS(ITERS)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .iter_o   (iter),
        .last_o   (last),
        .done_o   (done_q)
    );

    gf_euclid_step #(.M(M), .TAPS(TAPS), .DW(DW)) i_step (
        .r_i     (dp_q.r),
        .s_i     (dp_q.s),
        .u_i     (dp_q.u),
        .v_i     (dp_q.v),
        .delta_i (dp_q.delta),
        .r_o     (r_nx),
        .s_o     (s_nx),
        .u_o     (u_nx),
        .v_o     (v_nx),
        .delta_o (delta_nx)
    );

    always_comb begin
        dp_d = dp_q;
        if (accept) begin
            dp_d.r     = {1'b0, operand_i};
            dp_d.s     = {1'b1, TAPS};
            dp_d.u     = {{(M-1){1'b0}}, 1'b1};
            dp_d.v     = '0;
            dp_d.delta = '0;
            dp_d.zero  = (operand_i == '0);
        end else if (iter) begin
            dp_d.r     = r_nx;
            dp_d.s     = s_nx;
            dp_d.u     = u_nx;
            dp_d.v     = v_nx;
            dp_d.delta = delta_nx;
            if (last) begin
                dp_d.result = dp_q.zero ? '0 : u_nx;
                dp_d.err    = dp_q.zero;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign result_o   = dp_q.result;
    assign zero_err_o = dp_q.err;
    assign done_o     = done_q;

    // R5
    zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && zero_err_o) |-> (result_o == '0));

    // R4
    nonzero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !zero_err_o) |-> (result_o != '0));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({result_o, zero_err_o}) |-> done_o);

    // R6
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iter && start_i) |=> (dp_q.zero == $past(dp_q.zero)));

    // R3
    delta_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_q.delta <= DW'(ITERS));

endmodule

// File: tb/test_gf_inverter.sv
module test_gf_inverter;

    localparam int M = 81;
    localparam logic [M-1:0] TAPS = 81'h11;
    localparam int DONE_EDGE = 2 * M + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [M-1:0] operand = '0;
    logic [M-1:0] result;
    logic         done;
    logic         zerr;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    gf_inverter i_gf_inverter (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .operand_i  (operand),
        .result_o   (result),
        .done_o     (done),
        .zero_err_o (zerr)
    );

    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] acc = '0;
        logic [M-1:0] sh = a;
        for (int i = 0; i < M; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[M-1] ? ({sh[M-2:0], 1'b0} ^ TAPS) : {sh[M-2:0], 1'b0};
        end
        return acc;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [M-1:0] act, input logic [M-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive a request on a falling edge and count falling edges until done.
    task automatic run_op(input logic [M-1:0] a, input bit poke, input logic [M-1:0] other,
                          output int n, output logic [M-1:0] res, output logic err);
        @(negedge clk);
        start = 1'b1;
        operand = a;
        n = 0;
        while (1) begin
            @(negedge clk);
            n++;
            if (n == 1) start = 1'b0;
            if (poke && n == 40) begin start = 1'b1; operand = other; end
            if (poke && n == 41) start = 1'b0;
            if (done || n > 1000) break;
        end
        res = result;
        err = zerr;
    endtask

    task automatic full_check(input logic [M-1:0] a, input bit poke, input logic [M-1:0] other, input string tag);
        int n;
        logic [M-1:0] res;
        logic err;
        run_op(a, poke, other, n, res, err);
        // R3: done must appear on falling edge 2m+1 after the drive edge
        check(n == DONE_EDGE, {tag, " R3 latency"}, M'(n), M'(DONE_EDGE));
        if (a == '0) begin
            check(res == '0, {tag, " R5 zero result"}, res, '0);
            check(err == 1'b1, {tag, " R5 zero flag"}, M'(err), M'(1));
        end else begin
            // R4 / R6: product with the captured operand must be 1
            check(ref_mul(a, res) == M'(1), {tag, " R4 product"}, ref_mul(a, res), M'(1));
            check(err == 1'b0, {tag, " R8 flag clear"}, M'(err), '0);
        end
        @(negedge clk);
        check(done == 1'b0, {tag, " R3 single pulse"}, M'(done), '0);
        // R7 hold after completion
        check(result == res && zerr == err, {tag, " R7 hold"}, result, res);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [M-1:0] a;
        int n;
        logic [M-1:0] res;
        logic err;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(done == 1'b0 && zerr == 1'b0 && result == '0, "R1 reset", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && result == '0, "R1 after release", result, '0);

        // R9 directed corners
        run_op(M'(1), 1'b0, '0, n, res, err);
        check(res == M'(1), "R9 inverse of one", res, M'(1));
        run_op(M'(2), 1'b0, '0, n, res, err);
        check(res == ((M'(1) << 80) | M'(8)), "R9 inverse of x", res, (M'(1) << 80) | M'(8));
        // R2 capture of a top-bit operand
        full_check(M'(1) << 80, 1'b0, '0, "R2 top bit");
        full_check({M{1'b1}}, 1'b0, '0, "R2 all ones");
        // R5 zero, then R8 recovery
        full_check('0, 1'b0, '0, "R5 zero");
        full_check(M'(3), 1'b0, '0, "R8 after zero");
        // R6 start while busy ignored
        full_check(M'(81'h1_2345_6789_abcd_ef01), 1'b1, M'(5), "R6 busy poke");
        full_check(M'(7), 1'b1, '0, "R6 poke with zero");

        // R4 random operands
        for (int k = 0; k < 24; k++) begin
            a = M'({$urandom, $urandom, $urandom});
            if (k % 4 == 3) a = M'(1) << ($urandom % M);
            if (a == '0) a = M'(1);
            full_check(a, 1'b0, '0, "R4 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule